// File: doc/BRIEF.md
# Switchable Domain Power Sequencer

This controller owns the control pins of one power-gated domain. On a power-down request it clamps the domain outputs, saves retained state, and then opens the power switch. On a power-up request it closes the switch and waits for the switch acknowledge that shows the supply is settled. It then pulses the domain reset, restores retained state, and finally removes the clamps. Each timed step lasts a programmable number of cycles. A status pair tells the surrounding logic whether a sequence is in flight and whether the domain is usable.

The switch acknowledge comes either from an external pin or from a built-in delay model, chosen by a parameter. The model makes the acknowledge follow the switch control after a programmable delay, in both directions. A timeout limit flags an acknowledge that is late. All pins are plain level control and status signals. There is no data stream, so no valid/ready handshake is involved.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the domain is reported on: `sw_on`=1, `iso_en`=0, `ret_save`=0, `ret_restore`=0, `dom_rst`=0, `busy`=0, `dom_on`=1, `ack_err`=0.
- R2: On `req_down` in the on state, `iso_en` rises in the first cycle. `ret_save` follows once the isolation lead step ends. `sw_on` falls in the cycle right after the last save cycle.
- R3: On `req_up` in the off state, `sw_on` rises in the first cycle. `dom_rst` follows only after the acknowledge, then `ret_restore`. `iso_en` falls in the cycle right after the last restore cycle.
- R4: `iso_en` is high in every cycle in which `sw_on` is low.
- R5: `ret_save`, `ret_restore` and `dom_rst` are asserted only while both `sw_on` and `iso_en` are high.
- R6: The isolation lead, save, reset and restore steps each last max(`cfg_hold`,1) cycles.
- R7: With the internal model (`USE_EXT_ACK`=0), the acknowledge changes `cfg_ack_delay`+1 cycles after `sw_on` changes. `dom_rst` therefore starts `cfg_ack_delay`+2 cycles after `sw_on` rises. With `USE_EXT_ACK`=1 the `sw_ack` pin is used instead.
- R8: Requests are ignored while `busy` is high. `req_down` in the off state and `req_up` in the on state have no effect.
- R9: While waiting for an acknowledge, `ack_err` rises once the wait reaches `cfg_ack_limit` cycles and the controller holds its step. When the acknowledge arrives the sequence continues and `ack_err` drops.
- R10: `busy` is high exactly while a sequence runs. `dom_on` is high only in the idle on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_down | input | 1 | Request to power the domain down |
| req_up | input | 1 | Request to power the domain up |
| sw_ack | input | 1 | External switch acknowledge (used when USE_EXT_ACK=1) |
| cfg_hold | input | HOLD_W | Cycles per timed step (0 acts as 1) |
| cfg_ack_delay | input | DLY_W | Modelled acknowledge delay |
| cfg_ack_limit | input | CNT_W | Acknowledge wait limit before error |
| iso_en | output | 1 | Isolation clamp enable |
| ret_save | output | 1 | Retention save strobe |
| sw_on | output | 1 | Power switch control, 1 = conducting |
| ret_restore | output | 1 | Retention restore strobe |
| dom_rst | output | 1 | Domain reset, active high |
| busy | output | 1 | Sequence in progress |
| dom_on | output | 1 | Domain powered and released |
| ack_err | output | 1 | Acknowledge wait exceeded limit |

## Verification
The bench builds the block with its default widths and the internal acknowledge model. This makes the acknowledge timing fully predictable from `cfg_ack_delay`, so exact cycle positions of every step can be checked. Hold values of 0, 1, 2 and 3 reach the clamped-to-one case and multi-cycle steps. An acknowledge delay of 20 against a limit of 3 reaches the timeout path and its recovery. Delay 4 with a large limit covers the normal path.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_ON,       // idle, domain powered
    ST_ISO,      // clamps raised, lead time
    ST_SAVE,     // retention save
    ST_OFFWAIT,  // switch open, awaiting ack low
    ST_OFF,      // idle, domain dark
    ST_ONWAIT,   // switch closed, awaiting ack high
    ST_RST,      // domain reset
    ST_RESTORE   // retention restore
  } seq_state_e;
endpackage

// File: rtl/pwr_ack_model.sv
module pwr_ack_model #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_ctl,
  input  logic [DLY_W-1:0] dly,
  output logic             ack
);
  logic [DLY_W-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      ack      <= 1'b1;
    end else if (sw_ctl != ack) begin
      if (wait_cnt >= dly) begin
        ack      <= sw_ctl;
        wait_cnt <= '0;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end else begin
      wait_cnt <= '0;
    end
  end
endmodule

// File: rtl/pwr_step_cnt.sv
module pwr_step_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clear)          count <= '0;
    else if (count != '1)    count <= count + 1'b1;
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int HOLD_W      = 8,
  parameter int CNT_W       = 12,
  parameter int DLY_W       = 8,
  parameter bit USE_EXT_ACK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_down,
  input  logic              req_up,
  input  logic              sw_ack,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic [DLY_W-1:0]  cfg_ack_delay,
  input  logic [CNT_W-1:0]  cfg_ack_limit,
  output logic              iso_en,
  output logic              ret_save,
  output logic              sw_on,
  output logic              ret_restore,
  output logic              dom_rst,
  output logic              busy,
  output logic              dom_on,
  output logic              ack_err
);
  import pwr_seq_pkg::*;

  localparam int HW = (CNT_W > HOLD_W) ? CNT_W : HOLD_W;

  seq_state_e state, state_nx;
  logic [CNT_W-1:0] step_cnt;
  logic             model_ack, ack;
  logic [HW-1:0]    hold_last;
  logic             hold_done, waiting;

  pwr_step_cnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state_nx != state),
    .count (step_cnt)
  );

  pwr_ack_model #(.DLY_W(DLY_W)) u_ack (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_ctl (sw_on),
    .dly    (cfg_ack_delay),
    .ack    (model_ack)
  );

  assign ack = USE_EXT_ACK ? sw_ack : model_ack;

  always_comb begin
    if (cfg_hold == '0) hold_last = '0;
    else                hold_last = HW'(cfg_hold) - 1'b1;
  end
  assign hold_done = HW'(step_cnt) >= hold_last;
  assign waiting   = (state == ST_OFFWAIT) || (state == ST_ONWAIT);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_ON:      if (req_down)  state_nx = ST_ISO;
      ST_ISO:     if (hold_done) state_nx = ST_SAVE;
      ST_SAVE:    if (hold_done) state_nx = ST_OFFWAIT;
      ST_OFFWAIT: if (!ack)      state_nx = ST_OFF;
      ST_OFF:     if (req_up)    state_nx = ST_ONWAIT;
      ST_ONWAIT:  if (ack)       state_nx = ST_RST;
      ST_RST:     if (hold_done) state_nx = ST_RESTORE;
      ST_RESTORE: if (hold_done) state_nx = ST_ON;
      default:                   state_nx = ST_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ON;
    else        state <= state_nx;
  end

  always_comb begin
    iso_en      = 1'b1;
    sw_on       = 1'b1;
    ret_save    = 1'b0;
    ret_restore = 1'b0;
    dom_rst     = 1'b0;
    unique case (state)
      ST_ON:      iso_en = 1'b0;
      ST_SAVE:    ret_save = 1'b1;
      ST_OFFWAIT: sw_on = 1'b0;
      ST_OFF:     sw_on = 1'b0;
      ST_RST:     dom_rst = 1'b1;
      ST_RESTORE: ret_restore = 1'b1;
      default:    ;
    endcase
  end

  assign busy    = (state != ST_ON) && (state != ST_OFF);
  assign dom_on  = (state == ST_ON);
  assign ack_err = waiting && (step_cnt >= cfg_ack_limit);
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_down,
  input logic req_up,
  input logic iso_en,
  input logic ret_save,
  input logic sw_on,
  input logic ret_restore,
  input logic dom_rst,
  input logic busy,
  input logic dom_on,
  input logic ack_err
);
  a_r4_iso_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_on |-> iso_en);
  a_r5_save_powered: assert property (@(posedge clk) disable iff (!rst_n)
    ret_save |-> (sw_on && iso_en));
  a_r5_restore_powered: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_restore || dom_rst) |-> (sw_on && iso_en));
  a_r2_save_then_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_on) |-> $past(ret_save));
  a_r3_release_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> $past(ret_restore));
  a_r3_reset_before_restore: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ret_restore) |-> $past(dom_rst));
  a_r9_err_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> busy);
  a_r10_on_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dom_on |-> !busy);
  a_r8_up_ignored_on: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_on && req_up && !req_down) |=> dom_on);
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_down    (req_down),
  .req_up      (req_up),
  .iso_en      (iso_en),
  .ret_save    (ret_save),
  .sw_on       (sw_on),
  .ret_restore (ret_restore),
  .dom_rst     (dom_rst),
  .busy        (busy),
  .dom_on      (dom_on),
  .ack_err     (ack_err)
);

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;
  localparam int HOLD_W = 8;
  localparam int CNT_W  = 12;
  localparam int DLY_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_down = 1'b0, req_up = 1'b0, sw_ack = 1'b0;
  logic [HOLD_W-1:0] cfg_hold = 8'd1;
  logic [DLY_W-1:0]  cfg_ack_delay = 8'd4;
  logic [CNT_W-1:0]  cfg_ack_limit = 12'd1000;
  logic iso_en, ret_save, sw_on, ret_restore, dom_rst, busy, dom_on, ack_err;

  int n_chk = 0, n_fail = 0, viol = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_seq_ctrl #(.HOLD_W(HOLD_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .USE_EXT_ACK(1'b0)) u_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_down(req_down), .req_up(req_up), .sw_ack(sw_ack),
    .cfg_hold(cfg_hold), .cfg_ack_delay(cfg_ack_delay), .cfg_ack_limit(cfg_ack_limit),
    .iso_en(iso_en), .ret_save(ret_save), .sw_on(sw_on), .ret_restore(ret_restore),
    .dom_rst(dom_rst), .busy(busy), .dom_on(dom_on), .ack_err(ack_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R4 / R5 invariants sampled every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (!sw_on && !iso_en) viol++;
      if ((ret_save || ret_restore || dom_rst) && !(sw_on && iso_en)) viol++;
    end
  end

  task automatic t_reset();
    chk(sw_on && !iso_en && !ret_save && !ret_restore && !dom_rst, "R1", "ctrl pins",
        {sw_on, iso_en, ret_save, ret_restore, dom_rst}, 5'b10000);
    chk(!busy && dom_on && !ack_err, "R1", "status", {busy, dom_on, ack_err}, 3'b010);
  endtask

  task automatic t_down(input int h);
    int he, ti, ts, toff, ns;
    he = (h == 0) ? 1 : h;
    ti = -1; ts = -1; toff = -1; ns = 0;
    cfg_hold = HOLD_W'(h);
    req_down = 1'b1;
    @(negedge clk);
    req_down = 1'b0;
    for (int i = 1; i < 400; i++) begin
      if (iso_en && ti < 0) ti = i;
      if (ret_save) begin ns++; if (ts < 0) ts = i; end
      if (!sw_on && toff < 0) toff = i;
      if (!busy) break;
      @(negedge clk);
    end
    chk(ti == 1, "R2", "iso first cycle", ti, 1);
    chk(ts - ti == he, "R6", "iso lead length", ts - ti, he);
    chk(ns == he, "R6", "save length", ns, he);
    chk(toff == ts + he, "R2", "switch off after save", toff, ts + he);
    chk(!dom_on && !sw_on && iso_en && !busy, "R10", "off idle status",
        {dom_on, sw_on, iso_en, busy}, 4'b0010);
  endtask

  task automatic t_up(input int h, input int d);
    int he, ton, tr, nr, tre, nre, tiso;
    he = (h == 0) ? 1 : h;
    ton = -1; tr = -1; nr = 0; tre = -1; nre = 0; tiso = -1;
    cfg_hold = HOLD_W'(h);
    cfg_ack_delay = DLY_W'(d);
    req_up = 1'b1;
    @(negedge clk);
    req_up = 1'b0;
    for (int i = 1; i < 400; i++) begin
      if (sw_on && ton < 0) ton = i;
      if (dom_rst) begin nr++; if (tr < 0) tr = i; end
      if (ret_restore) begin nre++; if (tre < 0) tre = i; end
      if (!iso_en && tiso < 0) tiso = i;
      if (!busy) break;
      @(negedge clk);
    end
    chk(ton == 1, "R3", "switch on first cycle", ton, 1);
    chk(tr - ton == d + 2, "R7", "ack wait before reset", tr - ton, d + 2);
    chk(nr == he, "R6", "reset length", nr, he);
    chk(tre == tr + he && nre == he, "R3", "restore after reset", tre, tr + he);
    chk(tiso == tre + he, "R3", "iso release after restore", tiso, tre + he);
    chk(dom_on && !busy && sw_on, "R10", "on idle status", {dom_on, busy, sw_on}, 3'b101);
  endtask

  task automatic t_ignore();
    cfg_hold = 8'd2;
    req_up = 1'b1;                  // R8: req_up while on
    repeat (4) @(negedge clk);
    req_up = 1'b0;
    chk(dom_on && !busy && !iso_en, "R8", "up ignored while on", {dom_on, busy, iso_en}, 3'b100);
    req_down = 1'b1;
    @(negedge clk);
    req_down = 1'b0;
    req_up = 1'b1;                  // R8: request during running sequence
    repeat (3) @(negedge clk);
    req_up = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(!dom_on && !sw_on && !busy, "R8", "up ignored while busy", {dom_on, sw_on, busy}, 3'b000);
    req_down = 1'b1;                // R8: req_down while off
    @(negedge clk);
    req_down = 1'b0;
    repeat (10) @(negedge clk);
    chk(!sw_on && iso_en && !busy && !ret_save, "R8", "down ignored while off",
        {sw_on, iso_en, busy, ret_save}, 4'b0100);
  endtask

  task automatic t_timeout();
    bit err_pre, err_post, saw_rst;
    err_pre = 0; err_post = 0; saw_rst = 0;
    cfg_hold = 8'd1;
    cfg_ack_delay = 8'd20;
    cfg_ack_limit = 12'd3;
    req_up = 1'b1;
    @(negedge clk);
    req_up = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (dom_rst) saw_rst = 1;
      if (ack_err && !saw_rst) err_pre = 1;
      if (ack_err && saw_rst) err_post = 1;
      if (!busy) break;
      @(negedge clk);
    end
    chk(err_pre, "R9", "error during late ack", err_pre, 1);
    chk(!err_post, "R9", "error clears after ack", err_post, 0);
    chk(dom_on && !ack_err, "R9", "sequence completes", {dom_on, ack_err}, 2'b10);
    cfg_ack_limit = 12'd1000;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_down(3);
    t_up(3, 4);
    t_down(0);
    t_up(1, 4);
    t_ignore();
    t_up(2, 4);
    t_down(1);
    t_timeout();
    chk(viol == 0, "R4", "iso/save/restore power invariants", viol, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule